// File: doc/BRIEF.md
# Dual-Direction Host Mailbox Buffer

This block is a byte-wide mailbox between a host bus agent and a local slave controller. It runs in one clock domain. It holds two independent first-in first-out byte queues. The downstream queue carries bytes from the host to the slave. The upstream queue carries bytes from the slave to the host. Each side reaches its queue through a single data strobe pair: a write strobe pushes into the queue that side feeds, and a read strobe pops from the queue that side drains. Read data follows the head of the queue without a cycle of delay. Each queue exposes its full flag, empty flag, occupancy count and sticky overflow flag to both sides, and each has its own one-cycle clear input. Data movement only happens while a two-bit queue select input holds the enabling code.

The block also carries a host-to-slave reset request flag. Only the host can raise it. Only the slave can drop it, and only after the slave has read it as set. A host-side view control decides whether the host sees the flag's true value or a constant zero.

Top module: `hs_mailbox`

## Requirements
- R1: Bytes written by the host leave the slave read port in write order. The downstream queue holds 64 bytes. `dn_full` is 1 exactly when the count is 64. A push and a pop in the same cycle both take effect and leave the count unchanged.
- R2: Bytes written by the slave leave the host read port in write order. The upstream queue has the same 64-byte capacity and the same count and flag behaviour.
- R3: A write into a full queue is discarded, leaves the count at 64, and sets that queue's overflow flag. The flag stays 1 until that queue is cleared.
- R4: While a queue is empty, its read data port shows 0x00, and a read strobe leaves the count at 0.
- R5: Data moves only when `fifo_sel` equals 2'b11. For the codes 2'b00, 2'b01 and 2'b10, write and read strobes leave the counts and the stored bytes unchanged, and both read data ports show 0x00.
- R6: A clear input pulse empties its queue on the next clock edge and drops its overflow flag, whatever the strobes are doing in that cycle.
- R7: A host write with data 1 to the reset request flag sets it, as seen on `s_rst_rdata` one cycle later. A host write with data 0 has no effect.
- R8: `h_rst_rdata` is 0 while `h_rst_view_en` is 0. While it is 1, `h_rst_rdata` equals the flag.
- R9: A slave write with data 0 clears the flag only if the slave has read the flag as 1 (a `s_rst_rd` strobe while it is set) since the flag was last set. Otherwise the write leaves the flag at 1. A slave write with data 1 has no effect.
- R10: If a host set and a qualifying slave clear happen in the same cycle, the flag stays 1 and the slave's record of having read it is dropped. The slave must read the flag again before a clear works.
- R11: After reset both queues are empty, both overflow flags are 0 and the reset request flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_sel | input | 2 | Queue select; 2'b11 enables data movement |
| h_wr | input | 1 | Host push strobe into the downstream queue |
| h_wdata | input | 8 | Host write byte |
| h_rd | input | 1 | Host pop strobe from the upstream queue |
| h_rdata | output | 8 | Head byte of the upstream queue |
| s_wr | input | 1 | Slave push strobe into the upstream queue |
| s_wdata | input | 8 | Slave write byte |
| s_rd | input | 1 | Slave pop strobe from the downstream queue |
| s_rdata | output | 8 | Head byte of the downstream queue |
| dn_clr | input | 1 | Clear pulse for the downstream queue |
| up_clr | input | 1 | Clear pulse for the upstream queue |
| dn_full | output | 1 | Downstream queue full |
| dn_empty | output | 1 | Downstream queue empty |
| dn_count | output | 7 | Downstream occupancy |
| dn_ovf | output | 1 | Downstream sticky overflow |
| up_full | output | 1 | Upstream queue full |
| up_empty | output | 1 | Upstream queue empty |
| up_count | output | 7 | Upstream occupancy |
| up_ovf | output | 1 | Upstream sticky overflow |
| h_rst_wr | input | 1 | Host write strobe to the reset request flag |
| h_rst_wdata | input | 1 | Host write value for the flag |
| h_rst_view_en | input | 1 | Lets the host see the true flag value |
| h_rst_rdata | output | 1 | Host view of the flag |
| s_rst_rd | input | 1 | Slave read strobe of the flag |
| s_rst_wr | input | 1 | Slave write strobe to the flag |
| s_rst_wdata | input | 1 | Slave write value for the flag |
| s_rst_rdata | output | 1 | True flag value seen by the slave |

## Verification
A wrong pointer shows up at once as a byte out of order or a repeated byte on the read port, and the next pop exposes it. A wrong count shows up within one cycle as a full or empty flag in the wrong place, and so does a queue boundary checked at 0, 63, 64 and 65 writes. A missing or stale "has read" record in the reset flag logic only appears when the slave writes 0: the flag then drops, or fails to drop, on the very next edge. For that reason, every slave clear in the bench is checked both with and without a prior read.

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic                         clr,
   input  logic                         wr,
   input  logic [WIDTH-1:0]             wdata,
   input  logic                         rd,
   output logic [WIDTH-1:0]             rdata,
   output logic                         full,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mbx_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mbx_fifo: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;
   logic             push, pop, spill;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign push  = en && wr && !full;
   assign pop   = en && rd && !empty;
   assign spill = en && wr && full;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   if (POW2) begin : g_wrap_free
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
   end

   assign rdata = (en && !empty) ? mem[rptr] : '0;

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (push) wptr <= wptr_nx;
         if (pop)  rptr <= rptr_nx;
         unique case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (spill) ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/mbx_rstflag.sv
module mbx_rstflag (
   input  logic clk,
   input  logic rst_n,
   input  logic h_wr,
   input  logic h_wdata,
   input  logic h_view_en,
   output logic h_rdata,
   input  logic s_rd,
   input  logic s_wr,
   input  logic s_wdata,
   output logic s_rdata
);
   logic flag, seen;
   logic host_set, slave_clr;

   assign host_set  = h_wr && h_wdata;
   assign slave_clr = s_wr && !s_wdata && seen;
   assign h_rdata   = h_view_en && flag;
   assign s_rdata   = flag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         seen <= 1'b0;
      end else if (host_set) begin
         flag <= 1'b1;
         seen <= 1'b0;
      end else if (slave_clr) begin
         flag <= 1'b0;
         seen <= 1'b0;
      end else if (s_rd && flag) begin
         seen <= 1'b1;
      end
   end
endmodule

// File: rtl/hs_mailbox.sv
module hs_mailbox #(
   parameter int         DATA_W      = 8,
   parameter int         FIFO_DEPTH  = 64,
   parameter logic [1:0] FIFO_ON_CODE = 2'b11,
   localparam int        CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fifo_sel,
   input  logic              h_wr,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              h_rd,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              s_wr,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              s_rd,
   output logic [DATA_W-1:0] s_rdata,
   input  logic              dn_clr,
   input  logic              up_clr,
   output logic              dn_full,
   output logic              dn_empty,
   output logic [CNT_W-1:0]  dn_count,
   output logic              dn_ovf,
   output logic              up_full,
   output logic              up_empty,
   output logic [CNT_W-1:0]  up_count,
   output logic              up_ovf,
   input  logic              h_rst_wr,
   input  logic              h_rst_wdata,
   input  logic              h_rst_view_en,
   output logic              h_rst_rdata,
   input  logic              s_rst_rd,
   input  logic              s_rst_wr,
   input  logic              s_rst_wdata,
   output logic              s_rst_rdata
);
   logic fifo_en;
   assign fifo_en = (fifo_sel == FIFO_ON_CODE);

   mbx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_dn (
      .clk(clk), .rst_n(rst_n), .en(fifo_en), .clr(dn_clr),
      .wr(h_wr), .wdata(h_wdata), .rd(s_rd), .rdata(s_rdata),
      .full(dn_full), .empty(dn_empty), .count(dn_count), .ovf(dn_ovf));

   mbx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_up (
      .clk(clk), .rst_n(rst_n), .en(fifo_en), .clr(up_clr),
      .wr(s_wr), .wdata(s_wdata), .rd(h_rd), .rdata(h_rdata),
      .full(up_full), .empty(up_empty), .count(up_count), .ovf(up_ovf));

   mbx_rstflag u_rf (
      .clk(clk), .rst_n(rst_n),
      .h_wr(h_rst_wr), .h_wdata(h_rst_wdata), .h_view_en(h_rst_view_en),
      .h_rdata(h_rst_rdata),
      .s_rd(s_rst_rd), .s_wr(s_rst_wr), .s_wdata(s_rst_wdata),
      .s_rdata(s_rst_rdata));
endmodule

// File: rtl/hs_mailbox_chk.sv
module hs_mailbox_chk #(
   parameter int         DATA_W       = 8,
   parameter int         FIFO_DEPTH   = 64,
   parameter logic [1:0] FIFO_ON_CODE = 2'b11,
   localparam int        CNT_W        = $clog2(FIFO_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        fifo_sel,
   input logic              h_wr,
   input logic              s_rd,
   input logic [DATA_W-1:0] s_rdata,
   input logic [DATA_W-1:0] h_rdata,
   input logic              dn_clr,
   input logic              up_clr,
   input logic              dn_full,
   input logic              dn_empty,
   input logic [CNT_W-1:0]  dn_count,
   input logic              dn_ovf,
   input logic              up_empty,
   input logic              up_ovf,
   input logic              h_rst_wr,
   input logic              h_rst_wdata,
   input logic              h_rst_view_en,
   input logic              h_rst_rdata,
   input logic              s_rst_wr,
   input logic              s_rst_wdata,
   input logic              s_rst_rdata
);
   logic on;
   assign on = (fifo_sel == FIFO_ON_CODE);

   assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_ovf && !dn_clr) |=> dn_ovf);
   assert_up_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (up_ovf && !up_clr) |=> up_ovf);
   assert_full_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (on && dn_full && h_wr && !s_rd && !dn_clr) |=> (dn_ovf && dn_count == CNT_W'(FIFO_DEPTH)));
   assert_empty_rdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_empty |-> s_rdata == '0) and (up_empty |-> h_rdata == '0));
   assert_disabled_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!on && !dn_clr) |=> $stable(dn_count));
   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_clr |=> (dn_empty && !dn_ovf)) and (up_clr |=> (up_empty && !up_ovf)));
   assert_host_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rst_wr && h_rst_wdata) |=> s_rst_rdata);
   assert_host_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !h_rst_view_en |-> !h_rst_rdata);
   assert_clear_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(s_rst_rdata) |-> $past(s_rst_wr && !s_rst_wdata && !(h_rst_wr && h_rst_wdata)));
endmodule

bind hs_mailbox hs_mailbox_chk #(
   .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .FIFO_ON_CODE(FIFO_ON_CODE)
) u_chk (.*);

// File: tb/hs_mailbox_test.sv
module hs_mailbox_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] fifo_sel = 2'b11;
   logic       h_wr = 0, h_rd = 0, s_wr = 0, s_rd = 0, dn_clr = 0, up_clr = 0;
   logic [7:0] h_wdata = 0, s_wdata = 0, h_rdata, s_rdata;
   logic       dn_full, dn_empty, dn_ovf, up_full, up_empty, up_ovf;
   logic [6:0] dn_count, up_count;
   logic       h_rst_wr = 0, h_rst_wdata = 0, h_rst_view_en = 0, h_rst_rdata;
   logic       s_rst_rd = 0, s_rst_wr = 0, s_rst_wdata = 0, s_rst_rdata;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   hs_mailbox uut (.*);

   function automatic logic [7:0] pat_dn(int i); return 8'((i * 37 + 5) & 255); endfunction
   function automatic logic [7:0] pat_up(int i); return 8'((i * 91 + 200) & 255); endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk); #1;
      h_wr = 0; h_rd = 0; s_wr = 0; s_rd = 0; dn_clr = 0; up_clr = 0;
      h_rst_wr = 0; s_rst_rd = 0; s_rst_wr = 0;
   endtask

   task automatic host_push(input logic [7:0] d);
      @(negedge clk); h_wr = 1; h_wdata = d; tick();
   endtask
   task automatic slave_push(input logic [7:0] d);
      @(negedge clk); s_wr = 1; s_wdata = d; tick();
   endtask
   task automatic slave_pop(input logic [7:0] exp, input string req);
      @(negedge clk); s_rd = 1; #1;
      chk(s_rdata == exp, req, s_rdata, exp);
      tick();
   endtask
   task automatic host_pop(input logic [7:0] exp, input string req);
      @(negedge clk); h_rd = 1; #1;
      chk(h_rdata == exp, req, h_rdata, exp);
      tick();
   endtask
   task automatic rf_host(input logic v);
      @(negedge clk); h_rst_wr = 1; h_rst_wdata = v; tick();
   endtask
   task automatic rf_sread;
      @(negedge clk); s_rst_rd = 1; tick();
   endtask
   task automatic rf_swrite(input logic v);
      @(negedge clk); s_rst_wr = 1; s_rst_wdata = v; tick();
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R11 reset state
      chk(dn_empty && up_empty && dn_count == 0 && up_count == 0, "R11 empty", dn_count, 0);
      chk(!dn_ovf && !up_ovf && !s_rst_rdata, "R11 flags", {dn_ovf, up_ovf, s_rst_rdata}, 0);

      // R1 fill downstream
      for (int i = 0; i < 64; i++) begin
         host_push(pat_dn(i));
         chk(dn_count == 7'(i + 1), "R1 count", dn_count, i + 1);
         chk(dn_full == (i == 63), "R1 full", dn_full, i == 63);
      end
      // R3 overflow
      host_push(8'hEE);
      chk(dn_count == 64 && dn_full, "R3 count", dn_count, 64);
      chk(dn_ovf == 1, "R3 ovf", dn_ovf, 1);
      for (int i = 0; i < 64; i++) begin
         slave_pop(pat_dn(i), "R1 order");
         chk(dn_count == 7'(63 - i), "R1 drain", dn_count, 63 - i);
         chk(dn_ovf == 1, "R3 sticky", dn_ovf, 1);
      end
      // R4 empty read
      slave_pop(8'h00, "R4 rdata");
      chk(dn_count == 0 && dn_empty, "R4 count", dn_count, 0);
      // R6 clear drops ovf
      @(negedge clk); dn_clr = 1; h_wr = 1; h_wdata = 8'h55; tick();
      chk(!dn_ovf && dn_count == 0, "R6 clr", {dn_ovf, dn_count}, 0);

      // R2 upstream order and full
      for (int i = 0; i < 64; i++) slave_push(pat_up(i));
      chk(up_full && up_count == 64, "R2 full", up_count, 64);
      slave_push(8'h11);
      chk(up_ovf && up_count == 64, "R3 up ovf", up_ovf, 1);
      for (int i = 0; i < 64; i++) host_pop(pat_up(i), "R2 order");
      chk(up_empty && up_count == 0, "R2 empty", up_count, 0);
      host_pop(8'h00, "R4 up rdata");
      chk(up_count == 0, "R4 up count", up_count, 0);
      @(negedge clk); up_clr = 1; tick();
      chk(!up_ovf, "R6 up clr", up_ovf, 0);

      // R1 simultaneous push and pop
      for (int i = 0; i < 3; i++) host_push(8'(10 + i));
      @(negedge clk); h_wr = 1; h_wdata = 8'd13; s_rd = 1; #1;
      chk(s_rdata == 8'd10, "R1 simul data", s_rdata, 10);
      tick();
      chk(dn_count == 3, "R1 simul count", dn_count, 3);
      // R6 clear of non-empty queue with strobes active
      for (int i = 0; i < 5; i++) slave_push(8'(i));
      @(negedge clk); up_clr = 1; s_wr = 1; h_rd = 1; tick();
      chk(up_count == 0 && up_empty, "R6 clr nonempty", up_count, 0);

      // R5 disabled codes
      for (int sel = 0; sel < 3; sel++) begin
         fifo_sel = 2'(sel);
         @(negedge clk); h_wr = 1; h_wdata = 8'hAA; s_rd = 1; s_wr = 1; h_rd = 1; #1;
         chk(s_rdata == 0 && h_rdata == 0, "R5 rdata", s_rdata, 0);
         tick();
         chk(dn_count == 3 && up_count == 0, "R5 count", dn_count, 3);
      end
      fifo_sel = 2'b11;
      slave_pop(8'd11, "R5 data kept");
      slave_pop(8'd12, "R5 data kept");
      slave_pop(8'd13, "R5 data kept");

      // R7 / R8
      rf_host(1'b0);
      chk(s_rst_rdata == 0, "R7 write0", s_rst_rdata, 0);
      rf_host(1'b1);
      chk(s_rst_rdata == 1, "R7 set", s_rst_rdata, 1);
      chk(h_rst_rdata == 0, "R8 masked", h_rst_rdata, 0);
      h_rst_view_en = 1; #1;
      chk(h_rst_rdata == 1, "R8 view", h_rst_rdata, 1);
      // R9
      rf_swrite(1'b0);
      chk(s_rst_rdata == 1, "R9 no read", s_rst_rdata, 1);
      rf_swrite(1'b1);
      chk(s_rst_rdata == 1, "R9 write1", s_rst_rdata, 1);
      rf_sread();
      rf_swrite(1'b0);
      chk(s_rst_rdata == 0 && h_rst_rdata == 0, "R9 clear", s_rst_rdata, 0);
      rf_swrite(1'b0);
      chk(s_rst_rdata == 0, "R9 stays", s_rst_rdata, 0);
      // R10 race
      rf_host(1'b1);
      rf_sread();
      @(negedge clk); h_rst_wr = 1; h_rst_wdata = 1; s_rst_wr = 1; s_rst_wdata = 0; tick();
      chk(s_rst_rdata == 1, "R10 set wins", s_rst_rdata, 1);
      rf_swrite(1'b0);
      chk(s_rst_rdata == 1, "R10 seen dropped", s_rst_rdata, 1);
      rf_sread();
      rf_swrite(1'b0);
      chk(s_rst_rdata == 0, "R10 reread clear", s_rst_rdata, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule